// File: doc/BRIEF.md
# Residue Adder for Moduli of the Form 2^N - 2^K - 1

This block adds two residues A and B, both N bits wide and both below M = 2^N - 2^K - 1, and returns (A + B) mod M. It serves as one channel of a residue-number datapath, for example as the accumulation adder in a filter tap chain. Callers must keep both operands inside [0, M-1]. Conversion into or out of residue form is not part of the block.

The sum is formed in a single carry pass. The constant 2^K + 1 is folded into the generate/propagate pre-processing. A carry-save step merges the constant bit at position K into the upper field. One parallel-prefix network then yields the carries of A + B + 2^K + 1. The carry leaving the top of that sum decides which result is correct. If it is set, the low N bits of the biased sum are the answer. If it is clear, a per-bit correction converts the biased carries back into the carries of plain A + B, using only group propagates. A last XOR layer forms the sum bits. A parameter selects the prefix topology, and another parameter inserts an output register.

Top module: `modadd_2n2k1`

## Requirements
- R1: The modulus is M = 2^N - 2^K - 1, and the parameters must satisfy 1 <= K <= N-2; other values stop elaboration. With N=8 and K=4, (M-1) + 1 returns 0.
- R2: For every A < M and B < M, sum equals (A + B) mod M.
- R3: When A + B < M, sum equals A + B.
- R4: When A + B >= M, sum equals the low N bits of A + B + 2^K + 1.
- R5: For in-range operands, sum is always below M.
- R6: When either operand is 0, sum equals the other operand.
- R7: With REG_OUT=1, sum shows the result for the operands present at the previous rising clock edge, and an active-low asynchronous reset forces sum to 0. With REG_OUT=0, sum is combinational.
- R8: With N=8 and K=4, both 100 + 53 and 200 + 192 give 153.
- R9: PREFIX_KIND=0 (log-depth sparse tree, fan-out doubling per level) and PREFIX_KIND=1 (log-depth dense tree, fan-out one) give identical sums for every operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| a | input | N | First residue, must be below M |
| b | input | N | Second residue, must be below M |
| sum | output | N | (a + b) mod M, registered when REG_OUT=1 |

## Verification
The bound checker tests on every clock the arithmetic identity of the output: the modular result, the two branches (no reduction versus biased sum with the top bit dropped), the range bound, the identity for a zero operand, and that sum is 0 when reset ends. It covers both the registered and the combinational build. Some behaviours need scenarios from the bench. These are exhaustive coverage of all operand pairs for the 8/4 configuration, the agreement of the two prefix topologies, the one-cycle latency under a queued reference, and a reset asserted in the middle of traffic.

// File: rtl/modadd_pkg.sv
package modadd_pkg;

   // prefix network variants
   localparam int PFX_SPARSE = 0;
   localparam int PFX_DENSE  = 1;

   function automatic int modulus(input int n, input int k);
      return (1 << n) - (1 << k) - 1;
   endfunction

endpackage

// File: rtl/modadd_pre.sv
// Pre-processing: generate/propagate pairs of A + B + 2^K + 1.
// Bit 0 folds the +1 into its generate; the upper field runs a
// carry-save step that absorbs the +2^K term.
module modadd_pre #(
   parameter int N = 8,
   parameter int K = 4
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   output logic [N-1:0] g,
   output logic [N-1:0] p,
   output logic         csa_co
);

   logic [N-1:0] hg;
   logic [N-1:0] hp;

   always_comb begin
      hg = a & b;
      hp = a ^ b;
      // bit 0 carries the +1: generate when either operand bit is set
      g[0] = hg[0] | hp[0];
      p[0] = hp[0];
      for (int i = 1; i < K; i++) begin
         g[i] = hg[i];
         p[i] = hp[i];
      end
      // bit K: half-sum plus constant one
      g[K] = hp[K];
      p[K] = ~hp[K];
      // upper field: half-sum paired with the shifted carry-save carry
      for (int i = K + 1; i < N; i++) begin
         g[i] = hp[i] & hg[i-1];
         p[i] = hp[i] ^ hg[i-1];
      end
      csa_co = hg[N-1];
   end

endmodule

// File: rtl/modadd_prefix.sv
// Parallel-prefix carry network; outputs G[i:0] for every bit.
module modadd_prefix #(
   parameter int W    = 8,
   parameter int KIND = 0
) (
   input  logic [W-1:0] g,
   input  logic [W-1:0] p,
   output logic [W-1:0] gg
);

   localparam int L = (W > 1) ? $clog2(W) : 1;

   logic gl [0:L][0:W-1];
   logic pl [0:L-1][0:W-1];

   for (genvar i = 0; i < W; i++) begin : g_seed
      assign gl[0][i] = g[i];
      assign pl[0][i] = p[i];
   end

   for (genvar lv = 0; lv < L; lv++) begin : g_level
      for (genvar i = 0; i < W; i++) begin : g_node
         localparam int SPARSE_J = (((i >> lv) & 1) == 1) ? (((i >> lv) << lv) - 1) : -1;
         localparam int DENSE_J  = (i >= (1 << lv)) ? (i - (1 << lv)) : -1;
         localparam int J        = (KIND == modadd_pkg::PFX_SPARSE) ? SPARSE_J : DENSE_J;
         if (J >= 0) begin : g_op
            assign gl[lv+1][i] = gl[lv][i] | (pl[lv][i] & gl[lv][J]);
            if (lv < L - 1) begin : g_pp
               assign pl[lv+1][i] = pl[lv][i] & pl[lv][J];
            end
         end else begin : g_pass
            assign gl[lv+1][i] = gl[lv][i];
            if (lv < L - 1) begin : g_pp
               assign pl[lv+1][i] = pl[lv][i];
            end
         end
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_out
      assign gg[i] = gl[L][i];
   end

endmodule

// File: rtl/modadd_correct.sv
// Carry correction and sum XOR layer.
module modadd_correct #(
   parameter int N = 8,
   parameter int K = 4
) (
   input  logic [N-1:0] p,
   input  logic [N-1:0] gg,
   input  logic         csa_co,
   output logic [N-1:0] s
);

   logic cout;
   logic run;
   logic rc;
   logic kick;

   always_comb begin
      // overflow of the biased sum selects the biased branch
      cout = gg[N-1] | csa_co;
      kick = 1'b0;
      rc   = 1'b0;
      run  = p[0];
      s[0] = p[0] ^ cout;
      // lower field and bit K: strip the +1 ripple through P[i-1:0]
      for (int i = 1; i <= K; i++) begin
         rc = gg[i-1] & (cout | ~run);
         if (i == K) begin
            s[i] = p[i] ^ rc ^ ~cout;
            // plain carry leaving bit K
            kick = ~p[i] & gg[i-1] & ~run;
         end else begin
            s[i] = p[i] ^ rc;
            run  = run & p[i];
         end
      end
      // upper field: keep a biased carry only if the chain above K+1
      // is broken or the plain carry out of bit K feeds it
      run = 1'b1;
      for (int i = K + 1; i < N; i++) begin
         rc   = gg[i-1] & (cout | ~run | kick);
         s[i] = p[i] ^ rc;
         run  = run & p[i];
      end
   end

endmodule

// File: rtl/modadd_2n2k1.sv
module modadd_2n2k1 #(
   parameter int N           = 8,
   parameter int K           = 4,
   parameter int PREFIX_KIND = 0,
   parameter bit REG_OUT     = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   output logic [N-1:0] sum
);

   // R1: legal parameter space
   if (K < 1 || K > N - 2) begin : g_bad_k
      $error("modadd_2n2k1: K must lie in 1..N-2");
   end
   if (PREFIX_KIND != modadd_pkg::PFX_SPARSE && PREFIX_KIND != modadd_pkg::PFX_DENSE) begin : g_bad_kind
      $error("modadd_2n2k1: unknown PREFIX_KIND");
   end

   logic [N-1:0] g;
   logic [N-1:0] p;
   logic [N-1:0] gg;
   logic         csa_co;
   logic [N-1:0] sum_c;

   modadd_pre #(.N(N), .K(K)) i_pre (
      .a      (a),
      .b      (b),
      .g      (g),
      .p      (p),
      .csa_co (csa_co)
   );

   modadd_prefix #(.W(N), .KIND(PREFIX_KIND)) i_prefix (
      .g  (g),
      .p  (p),
      .gg (gg)
   );

   modadd_correct #(.N(N), .K(K)) i_correct (
      .p      (p),
      .gg     (gg),
      .csa_co (csa_co),
      .s      (sum_c)
   );

   if (REG_OUT) begin : g_reg
      logic [N-1:0] sum_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sum_q <= '0;
         else        sum_q <= sum_c;
      end
      assign sum = sum_q;
   end else begin : g_comb
      assign sum = sum_c;
   end

endmodule

// File: rtl/modadd_2n2k1_chk.sv
module modadd_2n2k1_chk #(
   parameter int N       = 8,
   parameter int K       = 4,
   parameter bit REG_OUT = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] a,
   input logic [N-1:0] b,
   input logic [N-1:0] sum
);

   localparam int M    = modadd_pkg::modulus(N, K);
   localparam int BIAS = (1 << K) + 1;

   logic [N-1:0] a_q;
   logic [N-1:0] b_q;
   logic         q_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_vld <= 1'b0;
      else        q_vld <= 1'b1;
   end

   always_ff @(posedge clk) begin
      a_q <= a;
      b_q <= b;
   end

   int  opa;
   int  opb;
   logic chk_en;

   always_comb begin
      opa    = REG_OUT ? int'(a_q) : int'(a);
      opb    = REG_OUT ? int'(b_q) : int'(b);
      chk_en = REG_OUT ? q_vld : 1'b1;
   end

   p_modsum_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && opa < M && opb < M) |-> (int'(sum) == (opa + opb) % M));

   p_nowrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && opa < M && opb < M && opa + opb < M) |-> (int'(sum) == opa + opb));

   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && opa < M && opb < M && opa + opb >= M) |-> (int'(sum) == ((opa + opb + BIAS) % (1 << N))));

   p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && opa < M && opb < M) |-> (int'(sum) < M));

   p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && opa < M && opb == 0) |-> (int'(sum) == opa));

   if (REG_OUT) begin : g_rst_chk
      p_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rst_n) |-> (sum == '0));
   end

endmodule

bind modadd_2n2k1 modadd_2n2k1_chk #(.N(N), .K(K), .REG_OUT(REG_OUT)) i_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .a     (a),
   .b     (b),
   .sum   (sum)
);

// File: tb/test_modadd_2n2k1.sv
module test_modadd_2n2k1;

   localparam int CLK_PERIOD = 10;
   localparam int N = 8;
   localparam int K = 4;
   localparam int M = (1 << N) - (1 << K) - 1;

   logic         clk   = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] a     = '0;
   logic [N-1:0] b     = '0;
   logic [N-1:0] sum;
   logic [N-1:0] sum_d;

   int checks = 0;
   int errors = 0;
   int    exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   // registered, sparse prefix tree
   modadd_2n2k1 #(.N(N), .K(K), .PREFIX_KIND(0), .REG_OUT(1'b1)) i_modadd_2n2k1 (
      .clk (clk), .rst_n (rst_n), .a (a), .b (b), .sum (sum)
   );

   // combinational, dense prefix tree (R9)
   modadd_2n2k1 #(.N(N), .K(K), .PREFIX_KIND(1), .REG_OUT(1'b0)) i_dense (
      .clk (clk), .rst_n (rst_n), .a (a), .b (b), .sum (sum_d)
   );

   task automatic check(input string tag, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic compare_pending();
      if (exp_q.size() > 0) begin
         int    e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, int'(sum), e);
         check("R5 range", (int'(sum) < M) ? 1 : 0, 1);
      end
   endtask

   // one clock: check the previous result, drive new operands
   task automatic step(input int x, input int y, input string tag);
      @(negedge clk);
      compare_pending();
      a = x[N-1:0];
      b = y[N-1:0];
      exp_q.push_back((x + y) % M);
      tag_q.push_back(tag);
      #1;
      check("R9 dense tree", int'(sum_d), (x + y) % M);
   endtask

   task automatic drain();
      @(negedge clk);
      compare_pending();
   endtask

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R7 reset value", int'(sum), 0);
      rst_n = 1'b1;

      step(100, 53, "R8 first 153");
      step(200, 192, "R8 second 153");
      step(0, 0, "R3 zero plus zero");
      step(M - 1, 0, "R6 b zero");
      step(0, M - 1, "R6 a zero");
      step(37, 0, "R6 b zero mid");
      step(M - 1, 1, "R1 modulus wrap");
      step(M - 1, M - 1, "R4 maximum operands");
      step(100, 138, "R3 largest unreduced");
      step(120, 119, "R4 exact modulus");
      step(15, 1, "R3 low field ripple");
      step(16, 240 - 16 - 1, "R4 top field");
      drain();

      // reset in the middle of traffic clears the registered output
      @(negedge clk);
      a = 8'd77;
      b = 8'd88;
      rst_n = 1'b0;
      @(negedge clk);
      check("R7 mid-run reset", int'(sum), 0);
      rst_n = 1'b1;

      // exhaustive sweep of every in-range operand pair
      for (int x = 0; x < M; x++) begin
         for (int y = 0; y < M; y++) begin
            step(x, y, (x + y < M) ? "R2 sweep no-reduce" : "R2 sweep reduce");
         end
      end
      drain();

      finish_run();
   end

endmodule